// File: doc/BRIEF.md
# Programmable Interval Timer with Interrupt Routing

This block is one down-counting timer channel with a small register port. It also has an interrupt router that sends the channel's pending event onto any number of interrupt output lines. Software writes one control word that holds three things: a run bit, a repeat bit and a 29-bit preset. The counter then moves down by one on each cycle where the chosen tick enable is high. When it has counted through zero, it raises a pending flag. In repeat mode the counter reloads the preset and keeps going. Otherwise it stops after the first expiry.

The interval follows an n+1 rule: a preset of P gives an expiry P+1 ticks after the counter starts. A separate register picks which free-running tick enable drives the counter, the oscillator tick or the timestamp tick. Software reads the pending flag from a status word and clears it by writing a one to the same bit. Every interrupt line has its own 32-bit mask word, in which bit `TIMER_ID` stands for this channel. Each line is a level output that stays high while the flag is set and the line's mask bit is set.

The register port uses a single valid strobe with a write qualifier, a byte address and 32-bit data. Read data appears on the cycle after the read request.

Top module: `ptimer_top`

## Requirements
- R1: The control word is at byte offset 0x000. Bit 31 is run, bit 30 is repeat, bits 28:0 are the preset, and bit 29 always reads 0. A read returns the last value written.
- R2: A control write with run=1 and preset P makes the pending flag rise on the (P+1)-th selected tick after the write and not before.
- R3: With repeat=1, the counter reloads P on each expiry and the flag is set again after each further P+1 ticks.
- R4: With repeat=0, the counter stops after one expiry, and no further ticks set the flag again.
- R5: A control write with run=0 stops the counter at once, and later ticks do not set the flag.
- R6: The status word is at offset 0x004. Bit 30 reads as the pending flag. Writing 1 to bit 30 clears the flag, and writing 0 to bit 30 leaves it unchanged.
- R7: The source word is at offset 0x008, bits 1:0. Value 1 selects the oscillator tick and value 2 selects the timestamp tick. Values 0 and 3 select no tick, and the counter holds.
- R8: The mask word for line l is at offset 0x100+4*l. Output irq_line[l] is high exactly while the flag is set and bit TIMER_ID of that word is 1. Other mask bits have no effect on the output.
- R9: A control write with run=1 while the counter is running reloads the new preset and restarts the interval.
- R10: If a flag clear and an expiry happen in the same cycle, the flag stays set.
- R11: Read data is registered and valid on the cycle after the read request. Unmapped addresses read as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_valid | input | 1 | Register access strobe |
| reg_write | input | 1 | 1 = write, 0 = read |
| reg_addr | input | ADDR_W | Byte address |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, one cycle after the request |
| osc_tick | input | 1 | Oscillator tick enable |
| tsc_tick | input | 1 | Timestamp tick enable |
| irq_line | output | NUM_LINES | Level interrupt outputs, active high |

## Verification
The case hardest to reach from the ports is an expiry that falls in the same cycle as a flag-clear write. To create it, the bench runs repeat mode with preset 0, so that every tick expires the counter. It then drives the tick and the status write on the same clock edge. The n+1 rule is covered by a sweep of presets 0 to 6 in both modes. In that sweep the bench counts single tick pulses one at a time and checks the line after each pulse.

// File: rtl/ptimer_pkg.sv
package ptimer_pkg;

    localparam int unsigned DATA_W   = 32;
    localparam int unsigned PRESET_W = 29;

    localparam logic [11:0] OFS_CTRL = 12'h000;
    localparam logic [11:0] OFS_STAT = 12'h004;
    localparam logic [11:0] OFS_SRC  = 12'h008;
    localparam logic [11:0] OFS_MASK = 12'h100;

    localparam int unsigned BIT_RUN     = 31;
    localparam int unsigned BIT_REPEAT  = 30;
    localparam int unsigned BIT_PENDING = 30;

    typedef struct packed {
        logic                run;
        logic                repeat_en;
        logic                rsvd;
        logic [PRESET_W-1:0] preset;
    } ctrl_t;

    typedef enum logic [1:0] {
        SRC_OFF  = 2'd0,
        SRC_OSC  = 2'd1,
        SRC_TSC  = 2'd2,
        SRC_OFF3 = 2'd3
    } tick_src_e;

    function automatic ctrl_t word_to_ctrl(input logic [DATA_W-1:0] w);
        ctrl_t c;
        c.run       = w[BIT_RUN];
        c.repeat_en = w[BIT_REPEAT];
        c.rsvd      = 1'b0;
        c.preset    = w[PRESET_W-1:0];
        return c;
    endfunction

    function automatic logic pick_tick(input tick_src_e s, input logic osc, input logic tsc);
        case (s)
            SRC_OSC: return osc;
            SRC_TSC: return tsc;
            default: return 1'b0;
        endcase
    endfunction

endpackage

// File: rtl/ptimer_regfile.sv
module ptimer_regfile
    import ptimer_pkg::*;
#(
    parameter int unsigned ADDR_W    = 12,
    parameter int unsigned NUM_LINES = 4
) (
    input  logic                            clk,
    input  logic                            rst,
    input  logic                            reg_valid,
    input  logic                            reg_write,
    input  logic [ADDR_W-1:0]               reg_addr,
    input  logic [DATA_W-1:0]               reg_wdata,
    output logic [DATA_W-1:0]               reg_rdata,
    input  logic                            pending,
    output ctrl_t                           ctrl,
    output tick_src_e                       src,
    output logic [NUM_LINES-1:0][DATA_W-1:0] masks,
    output logic                            load,
    output logic [PRESET_W-1:0]             load_value,
    output logic                            stop,
    output logic                            clear
);
    localparam int unsigned MASK_END = int'(OFS_MASK) + 4 * NUM_LINES;
    localparam int unsigned LINE_W   = (NUM_LINES > 1) ? $clog2(NUM_LINES) : 1;

    logic wr, rd;
    logic hit_ctrl, hit_stat, hit_src, hit_mask;
    logic [ADDR_W-1:0] mask_off;
    logic [LINE_W-1:0] line_sel;

    assign wr = reg_valid & reg_write;
    assign rd = reg_valid & ~reg_write;

    assign hit_ctrl = (reg_addr == ADDR_W'(OFS_CTRL));
    assign hit_stat = (reg_addr == ADDR_W'(OFS_STAT));
    assign hit_src  = (reg_addr == ADDR_W'(OFS_SRC));
    assign hit_mask = (int'(reg_addr) >= int'(OFS_MASK)) &&
                      (int'(reg_addr) < int'(MASK_END)) &&
                      (reg_addr[1:0] == 2'b00);
    assign mask_off = reg_addr - ADDR_W'(OFS_MASK);
    assign line_sel = LINE_W'(mask_off >> 2);

    assign load       = wr & hit_ctrl & reg_wdata[BIT_RUN];
    assign stop       = wr & hit_ctrl & ~reg_wdata[BIT_RUN];
    assign load_value = reg_wdata[PRESET_W-1:0];
    assign clear      = wr & hit_stat & reg_wdata[BIT_PENDING];

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl <= '0;
            src  <= SRC_OFF;
        end else if (wr) begin
            if (hit_ctrl) ctrl <= word_to_ctrl(reg_wdata);
            if (hit_src)  src  <= tick_src_e'(reg_wdata[1:0]);
        end
    end

    for (genvar l = 0; l < NUM_LINES; l++) begin : g_mask
        always_ff @(posedge clk) begin
            if (rst)
                masks[l] <= '0;
            else if (wr && hit_mask && (int'(line_sel) == l))
                masks[l] <= reg_wdata;
        end
    end

    logic [DATA_W-1:0] rd_mux;
    always_comb begin
        rd_mux = '0;
        if (hit_ctrl)
            rd_mux = ctrl;
        else if (hit_stat)
            rd_mux[BIT_PENDING] = pending;
        else if (hit_src)
            rd_mux[1:0] = src;
        else if (hit_mask)
            rd_mux = masks[line_sel];
    end

    always_ff @(posedge clk) begin
        if (rst)
            reg_rdata <= '0;
        else if (rd)
            reg_rdata <= rd_mux;
    end

    assert_ctrl_rsvd_R1: assert property (@(posedge clk) disable iff (rst)
        wr && hit_ctrl |=> ctrl.rsvd == 1'b0);

    assert_rd_latency_R11: assert property (@(posedge clk) disable iff (rst)
        !rd |=> $stable(reg_rdata));

endmodule

// File: rtl/ptimer_counter.sv
module ptimer_counter
    import ptimer_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                osc_tick,
    input  logic                tsc_tick,
    input  tick_src_e           src,
    input  logic                load,
    input  logic [PRESET_W-1:0] load_value,
    input  logic                stop,
    input  logic                repeat_en,
    input  logic [PRESET_W-1:0] preset,
    output logic                expire
);
    logic                running;
    logic [PRESET_W-1:0] count;
    logic                tick;

    assign tick   = pick_tick(src, osc_tick, tsc_tick);
    assign expire = running & tick & (count == '0) & ~load & ~stop;

    always_ff @(posedge clk) begin
        if (rst) begin
            running <= 1'b0;
            count   <= '0;
        end else if (load) begin
            running <= 1'b1;
            count   <= load_value;
        end else if (stop) begin
            running <= 1'b0;
        end else if (running && tick) begin
            if (count == '0) begin
                if (repeat_en)
                    count <= preset;
                else
                    running <= 1'b0;
            end else begin
                count <= count - 1'b1;
            end
        end
    end

    assert_hold_no_tick_R7: assert property (@(posedge clk) disable iff (rst)
        !load && !tick |=> $stable(count));

    assert_reload_R3: assert property (@(posedge clk) disable iff (rst)
        expire && repeat_en |=> running && count == $past(preset));

    assert_oneshot_halts_R4: assert property (@(posedge clk) disable iff (rst)
        expire && !repeat_en |=> !running);

    assert_stop_now_R5: assert property (@(posedge clk) disable iff (rst)
        stop && !load |=> !running);

    assert_restart_R9: assert property (@(posedge clk) disable iff (rst)
        load |=> running && count == $past(load_value));

endmodule

// File: rtl/ptimer_pending.sv
module ptimer_pending (
    input  logic clk,
    input  logic rst,
    input  logic set,
    input  logic clear,
    output logic flag
);
    always_ff @(posedge clk) begin
        if (rst)
            flag <= 1'b0;
        else if (set)
            flag <= 1'b1;
        else if (clear)
            flag <= 1'b0;
    end

    assert_set_wins_R10: assert property (@(posedge clk) disable iff (rst)
        set |=> flag);

    assert_w1c_R6: assert property (@(posedge clk) disable iff (rst)
        clear && !set |=> !flag);

    assert_sticky_R6: assert property (@(posedge clk) disable iff (rst)
        flag && !clear |=> flag);

endmodule

// File: rtl/ptimer_router.sv
module ptimer_router
    import ptimer_pkg::*;
#(
    parameter int unsigned NUM_LINES = 4,
    parameter int unsigned TIMER_ID  = 2
) (
    input  logic                             pending,
    input  logic [NUM_LINES-1:0][DATA_W-1:0] masks,
    output logic [NUM_LINES-1:0]             irq_line
);
    for (genvar l = 0; l < NUM_LINES; l++) begin : g_line
        assign irq_line[l] = pending & masks[l][TIMER_ID];
    end
endmodule

// File: rtl/ptimer_top.sv
module ptimer_top
    import ptimer_pkg::*;
#(
    parameter int unsigned ADDR_W    = 12,
    parameter int unsigned NUM_LINES = 4,
    parameter int unsigned TIMER_ID  = 2
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 reg_valid,
    input  logic                 reg_write,
    input  logic [ADDR_W-1:0]    reg_addr,
    input  logic [31:0]          reg_wdata,
    output logic [31:0]          reg_rdata,
    input  logic                 osc_tick,
    input  logic                 tsc_tick,
    output logic [NUM_LINES-1:0] irq_line
);
    ctrl_t                            ctrl;
    tick_src_e                        src;
    logic [NUM_LINES-1:0][DATA_W-1:0] masks;
    logic                             load, stop, clear, expire, pending;
    logic [PRESET_W-1:0]              load_value;

    ptimer_regfile #(.ADDR_W(ADDR_W), .NUM_LINES(NUM_LINES)) u_regs (
        .clk(clk), .rst(rst),
        .reg_valid(reg_valid), .reg_write(reg_write), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .pending(pending), .ctrl(ctrl), .src(src), .masks(masks),
        .load(load), .load_value(load_value), .stop(stop), .clear(clear)
    );

    ptimer_counter u_cnt (
        .clk(clk), .rst(rst), .osc_tick(osc_tick), .tsc_tick(tsc_tick),
        .src(src), .load(load), .load_value(load_value), .stop(stop),
        .repeat_en(ctrl.repeat_en), .preset(ctrl.preset), .expire(expire)
    );

    ptimer_pending u_pend (
        .clk(clk), .rst(rst), .set(expire), .clear(clear), .flag(pending)
    );

    ptimer_router #(.NUM_LINES(NUM_LINES), .TIMER_ID(TIMER_ID)) u_route (
        .pending(pending), .masks(masks), .irq_line(irq_line)
    );

    assert_irq_needs_flag_R8: assert property (@(posedge clk) disable iff (rst)
        |irq_line |-> pending);

    assert_expire_flags_R2: assert property (@(posedge clk) disable iff (rst)
        expire |=> pending);

endmodule

// File: tb/ptimer_top_test.sv
module ptimer_top_test;
    localparam int ADDR_W = 12;
    localparam int NL     = 4;
    localparam int TID    = 2;

    logic clk = 0, rst = 1;
    logic reg_valid = 0, reg_write = 0;
    logic [ADDR_W-1:0] reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic osc_tick = 0, tsc_tick = 0;
    logic [NL-1:0] irq_line;

    int checks = 0, errors = 0;
    bit done = 0;

    always #10 clk = ~clk;

    ptimer_top #(.ADDR_W(ADDR_W), .NUM_LINES(NL), .TIMER_ID(TID)) uut (
        .clk(clk), .rst(rst), .reg_valid(reg_valid), .reg_write(reg_write),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .osc_tick(osc_tick), .tsc_tick(tsc_tick), .irq_line(irq_line)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [11:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_valid = 1; reg_write = 1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_valid = 0; reg_write = 0;
    endtask

    task automatic rd(input logic [11:0] a, output logic [31:0] d);
        @(negedge clk);
        reg_valid = 1; reg_write = 0; reg_addr = a;
        @(negedge clk);
        reg_valid = 0;
        d = reg_rdata;
    endtask

    task automatic pulse(input bit osc, input bit tsc);
        @(negedge clk);
        osc_tick = osc; tsc_tick = tsc;
        @(negedge clk);
        osc_tick = 0; tsc_tick = 0;
    endtask

    function automatic logic [31:0] ctrl_word(bit run, bit rep, int p);
        return {run, rep, 1'b0, 29'(p)};
    endfunction

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=hung expected=done");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        logic [31:0] r;
        repeat (3) @(negedge clk);
        rst = 0;
        @(negedge clk);
        // reset state
        check("R8 reset irq", 32'(irq_line), 0);
        rd(12'h000, r); check("R1 reset ctrl", r, 0);
        rd(12'h004, r); check("R6 reset status", r, 0);
        rd(12'h008, r); check("R7 reset src", r, 0);
        rd(12'h200, r); check("R11 unmapped", r, 0);

        // R1 readback, bit 29 reads 0
        wr(12'h000, 32'hFFFF_FFFF);
        rd(12'h000, r); check("R1 ctrl readback", r, 32'hDFFF_FFFF);
        wr(12'h000, 32'h0);
        rd(12'h000, r); check("R1 ctrl zero", r, 0);

        wr(12'h008, 1);
        rd(12'h008, r); check("R7 src readback", r, 1);
        wr(12'h100, 32'(1) << TID);
        rd(12'h100, r); check("R8 mask readback", r, 32'(1) << TID);

        // R2/R3/R4 sweep over presets and modes
        for (int rep = 0; rep < 2; rep++) begin
            for (int p = 0; p <= 6; p++) begin
                wr(12'h000, ctrl_word(1, rep[0], p));
                for (int t = 1; t <= p + 1; t++) begin
                    pulse(1, 0);
                    check((t <= p) ? "R2 early" : "R2 expiry", 32'(irq_line[0]), (t == p + 1) ? 1 : 0);
                end
                rd(12'h004, r); check("R6 status set", r, 32'h4000_0000);
                wr(12'h004, 32'h4000_0000);
                check("R6 cleared", 32'(irq_line[0]), 0);
                if (rep == 1) begin
                    for (int t = 1; t <= p + 1; t++) pulse(1, 0);
                    check("R3 periodic again", 32'(irq_line[0]), 1);
                    wr(12'h004, 32'h4000_0000);
                end else begin
                    for (int t = 0; t < 2 * p + 4; t++) pulse(1, 0);
                    check("R4 oneshot stays", 32'(irq_line[0]), 0);
                end
                wr(12'h000, 0);
            end
        end

        // R5 stop
        wr(12'h000, ctrl_word(1, 1, 3));
        pulse(1, 0); pulse(1, 0);
        wr(12'h000, ctrl_word(0, 1, 3));
        for (int t = 0; t < 8; t++) pulse(1, 0);
        check("R5 stopped", 32'(irq_line[0]), 0);

        // R6 writing 0 does not clear
        wr(12'h000, ctrl_word(1, 0, 0));
        pulse(1, 0);
        wr(12'h004, 32'hBFFF_FFFF);
        check("R6 write0 keeps", 32'(irq_line[0]), 1);
        wr(12'h004, 32'h4000_0000);

        // R7 source select
        wr(12'h008, 2);
        wr(12'h000, ctrl_word(1, 0, 1));
        pulse(1, 0); pulse(1, 0); pulse(1, 0);
        check("R7 osc ignored under tsc", 32'(irq_line[0]), 0);
        pulse(0, 1); pulse(0, 1);
        check("R7 tsc counts", 32'(irq_line[0]), 1);
        wr(12'h004, 32'h4000_0000);
        for (int s = 0; s < 4; s += 3) begin
            wr(12'h008, s);
            wr(12'h000, ctrl_word(1, 0, 0));
            pulse(1, 1); pulse(1, 1); pulse(1, 1);
            check("R7 no tick holds", 32'(irq_line[0]), 0);
            wr(12'h008, 1);
            pulse(1, 0);
            check("R7 resumes after select", 32'(irq_line[0]), 1);
            wr(12'h004, 32'h4000_0000);
        end

        // R9 restart
        wr(12'h000, ctrl_word(1, 0, 4));
        pulse(1, 0); pulse(1, 0); pulse(1, 0);
        wr(12'h000, ctrl_word(1, 0, 4));
        for (int t = 0; t < 4; t++) pulse(1, 0);
        check("R9 not yet after restart", 32'(irq_line[0]), 0);
        pulse(1, 0);
        check("R9 fires after restart", 32'(irq_line[0]), 1);
        wr(12'h004, 32'h4000_0000);

        // R10 set wins over simultaneous clear
        wr(12'h000, ctrl_word(1, 1, 0));
        pulse(1, 0);
        check("R10 flag set", 32'(irq_line[0]), 1);
        @(negedge clk);
        osc_tick = 1; reg_valid = 1; reg_write = 1; reg_addr = 12'h004; reg_wdata = 32'h4000_0000;
        @(negedge clk);
        osc_tick = 0; reg_valid = 0; reg_write = 0;
        check("R10 set wins", 32'(irq_line[0]), 1);
        wr(12'h004, 32'h4000_0000);
        check("R10 clear alone", 32'(irq_line[0]), 0);
        wr(12'h000, 0);

        // R8 routing
        wr(12'h104, 0);
        wr(12'h108, ~(32'(1) << TID));
        wr(12'h10C, 32'hFFFF_FFFF);
        rd(12'h108, r); check("R8 mask2 readback", r, ~(32'(1) << TID));
        check("R8 idle lines", 32'(irq_line), 0);
        wr(12'h000, ctrl_word(1, 0, 0));
        pulse(1, 0);
        check("R8 routed lines", 32'(irq_line), 32'b1001);
        wr(12'h004, 32'h4000_0000);
        check("R8 lines drop", 32'(irq_line), 0);

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule